// File: doc/BRIEF.md
# Multi-Mode 24-Bit Up/Down Counter

This block is a synchronous up/down counter whose value moves one step for every clock cycle in which the count strobe is high. The direction input picks the step direction. A preset word supplied at a port serves as the load value and as the comparison value. It also sets the boundary for the range-limited and modulo-N modes. Arithmetic is either plain binary or six packed BCD digits.

Besides the count value, the block produces three active-low pulses: carry on overflow, borrow on underflow, and compare when a step lands on the preset. It also keeps an 8-bit status word with toggle bits, a sign bit, the last direction, a sticky noise-error bit and the registered index level. Strobes clear the counter, load it from the preset, clear the event flags and clear the error bit. The count strobe is expected to come from an input filter/decoder that lies outside this block.

Top module: `mode_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count is set to 0, every status bit is set to 0, and all three pulse outputs go high.
- R2: A cycle with `mode_wr` high stores `mode_data`, and pulses from the next cycle on use it. Bit 0 selects binary (0) or BCD (1). Bits 2:1 select the mode: 00 free-running, 01 range-limited, 10 one-shot (non-recycle), 11 modulo-N.
- R3: In free-running binary mode, each accepted pulse adds or subtracts one. Counting up from FFFFFF gives 0 and a carry pulse. Counting down from 0 gives FFFFFF and a borrow pulse.
- R4: In BCD arithmetic, each nibble is a decimal digit, the range is 000000 to 999999, and digits ripple in decimal. In free-running mode, up from 999999 gives 0 with a carry, and down from 0 gives 999999 with a borrow.
- R5: In range-limited mode, a pulse counting up while the count equals the preset leaves the count unchanged, and so does a pulse counting down at 0. Neither raises carry or borrow. A pulse in the opposite direction moves the count again.
- R6: In one-shot mode, an up pulse at the top value gives a carry, and a down pulse at 0 gives a borrow. In both cases the count keeps its terminal value and later pulses are ignored until a clear, a load or a mode write.
- R7: In modulo-N mode, counting up from a count equal to the preset gives 0 with a carry. Counting down from 0 gives the preset value with a borrow.
- R8: Any accepted pulse whose resulting count equals the preset drives `compare_n` low.
- R9: `carry_n`, `borrow_n` and `compare_n` go low for exactly one cycle, in the same cycle the new count appears. Carry and borrow are never low together.
- R10: Status bit 0 toggles on every borrow, bit 1 on every carry, and bit 2 on every compare.
- R11: Status bit 3 is set by a borrow and cleared by a carry. Bit 5 holds the direction of the last accepted pulse (1 = up). Bit 6 shows `idx_in` one cycle later. Bit 7 is always 0.
- R12: Status bit 4 is set by `err_in` and stays set until `clr_err`, which wins over a simultaneous `err_in`. `clr_flags` does not affect bit 4.
- R13: Priority: `clr_pulse` over `load_pulse` over a count pulse. A count pulse in a clear or load cycle is ignored. `clr_flags` zeroes bits 3:0 and wins over simultaneous events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Store `mode_data` into the mode register |
| mode_data | input | 3 | Mode word: bit 0 BCD, bits 2:1 count mode |
| preset_in | input | 24 | Preset/load/compare value |
| cnt_pulse | input | 1 | Count strobe, one step per high cycle |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| load_pulse | input | 1 | Copy preset into the counter |
| clr_pulse | input | 1 | Clear the counter to 0 |
| clr_flags | input | 1 | Clear status bits 3:0 |
| clr_err | input | 1 | Clear status bit 4 |
| err_in | input | 1 | Noise-error event from the input filter |
| idx_in | input | 1 | Active index level |
| count_out | output | 24 | Current count |
| flags_out | output | 8 | Status word |
| carry_n | output | 1 | Active-low carry pulse |
| borrow_n | output | 1 | Active-low borrow pulse |
| compare_n | output | 1 | Active-low compare pulse |

## Verification
Every result of a strobe appears one clock edge after the cycle in which the strobe was held high. This covers the new count, the three pulses, the status bits and the registered index. A mode write affects only pulses from the following cycle. The bench therefore changes inputs at the falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Each table vector spends separate cycles on mode write, load and the single count pulse. The check that a pulse lasts exactly one cycle samples one further falling edge later.

// File: rtl/mode_counter_pkg.sv
package mode_counter_pkg;

  typedef enum logic [1:0] {
    CM_FREE    = 2'b00,
    CM_CLAMP   = 2'b01,
    CM_ONESHOT = 2'b10,
    CM_WRAPN   = 2'b11
  } cmode_e;

  localparam int FLAG_W  = 8;
  localparam int FLG_BT  = 0;
  localparam int FLG_CT  = 1;
  localparam int FLG_CPT = 2;
  localparam int FLG_SGN = 3;
  localparam int FLG_ERR = 4;
  localparam int FLG_DIR = 5;
  localparam int FLG_IDX = 6;

endpackage

// File: rtl/mc_step.sv
// Next value of the counter one step up or down, binary or packed decimal.
module mc_step #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] value,
  input  logic             up,
  input  logic             bcd,
  output logic [WIDTH-1:0] nxt
);
  localparam int DIGITS = WIDTH / 4;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] bin_nxt;
  logic [WIDTH-1:0] dec_nxt;

  assign bin_nxt = up ? value + ONE : value - ONE;

  always_comb begin
    logic       ripple;
    logic [3:0] d;
    ripple  = 1'b1;
    dec_nxt = '0;
    for (int i = 0; i < DIGITS; i++) begin
      d = value[4*i +: 4];
      if (!ripple) begin
        dec_nxt[4*i +: 4] = d;
      end else if (up) begin
        if (d >= 4'd9) begin
          dec_nxt[4*i +: 4] = 4'd0;
        end else begin
          dec_nxt[4*i +: 4] = d + 4'd1;
          ripple = 1'b0;
        end
      end else begin
        if (d == 4'd0) begin
          dec_nxt[4*i +: 4] = 4'd9;
        end else begin
          dec_nxt[4*i +: 4] = d - 4'd1;
          ripple = 1'b0;
        end
      end
    end
  end

  assign nxt = bcd ? dec_nxt : bin_nxt;

endmodule

// File: rtl/mc_count_ctrl.sv
// Count register with mode-dependent boundary handling and event detection.
module mc_count_ctrl
  import mode_counter_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_pulse,
  input  logic             cnt_up,
  input  logic             load_pulse,
  input  logic             clr_pulse,
  input  logic             mode_wr,
  input  cmode_e           mode,
  input  logic             bcd,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count_q,
  output logic             accept,
  output logic             carry_ev,
  output logic             borrow_ev,
  output logic             cmp_ev
);
  localparam int DIGITS = WIDTH / 4;
  localparam logic [WIDTH-1:0] BIN_TOP = '1;
  localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'({DIGITS{4'h9}});

  logic             halted_q;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] nxt;
  logic             at_top, at_zero, at_pre;
  logic             over_raw, under_raw;

  mc_step #(.WIDTH(WIDTH)) u_step (
    .value (count_q),
    .up    (cnt_up),
    .bcd   (bcd),
    .nxt   (stepped)
  );

  assign at_top  = (count_q == (bcd ? DEC_TOP : BIN_TOP));
  assign at_zero = (count_q == '0);
  assign at_pre  = (count_q == preset);
  assign accept  = cnt_pulse & ~halted_q & ~clr_pulse & ~load_pulse;

  always_comb begin
    nxt       = stepped;
    over_raw  = 1'b0;
    under_raw = 1'b0;
    case (mode)
      CM_FREE: begin
        over_raw  = cnt_up & at_top;
        under_raw = ~cnt_up & at_zero;
      end
      CM_CLAMP: begin
        if ((cnt_up & at_pre) | (~cnt_up & at_zero)) nxt = count_q;
      end
      CM_ONESHOT: begin
        over_raw  = cnt_up & at_top;
        under_raw = ~cnt_up & at_zero;
        if (over_raw | under_raw) nxt = count_q;
      end
      CM_WRAPN: begin
        over_raw  = cnt_up & at_pre;
        under_raw = ~cnt_up & at_zero;
        if (over_raw)       nxt = '0;
        else if (under_raw) nxt = preset;
      end
      default: nxt = stepped;
    endcase
  end

  assign carry_ev  = accept & over_raw;
  assign borrow_ev = accept & under_raw;
  assign cmp_ev    = accept & (nxt == preset);

  always_ff @(posedge clk) begin
    if (rst || clr_pulse) begin
      count_q  <= '0;
      halted_q <= 1'b0;
    end else if (load_pulse) begin
      count_q  <= preset;
      halted_q <= 1'b0;
    end else begin
      if (accept) count_q <= nxt;
      if (mode_wr)
        halted_q <= 1'b0;
      else if (mode == CM_ONESHOT && (carry_ev || borrow_ev))
        halted_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mc_flags.sv
// Status word: toggles, sign, sticky error, direction, index.
module mc_flags
  import mode_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              cnt_up,
  input  logic              carry_ev,
  input  logic              borrow_ev,
  input  logic              cmp_ev,
  input  logic              err_in,
  input  logic              idx_in,
  input  logic              clr_flags,
  input  logic              clr_err,
  output logic [FLAG_W-1:0] flags
);
  logic bt_q, ct_q, cpt_q, sgn_q, err_q, dir_q, idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bt_q  <= 1'b0;
      ct_q  <= 1'b0;
      cpt_q <= 1'b0;
      sgn_q <= 1'b0;
      err_q <= 1'b0;
      dir_q <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      if (clr_flags) begin
        bt_q  <= 1'b0;
        ct_q  <= 1'b0;
        cpt_q <= 1'b0;
        sgn_q <= 1'b0;
      end else begin
        bt_q  <= bt_q ^ borrow_ev;
        ct_q  <= ct_q ^ carry_ev;
        cpt_q <= cpt_q ^ cmp_ev;
        if (borrow_ev)     sgn_q <= 1'b1;
        else if (carry_ev) sgn_q <= 1'b0;
      end
      if (clr_err)     err_q <= 1'b0;
      else if (err_in) err_q <= 1'b1;
      if (accept) dir_q <= cnt_up;
      idx_q <= idx_in;
    end
  end

  always_comb begin
    flags          = '0;
    flags[FLG_BT]  = bt_q;
    flags[FLG_CT]  = ct_q;
    flags[FLG_CPT] = cpt_q;
    flags[FLG_SGN] = sgn_q;
    flags[FLG_ERR] = err_q;
    flags[FLG_DIR] = dir_q;
    flags[FLG_IDX] = idx_q;
  end

endmodule

// File: rtl/mode_counter.sv
module mode_counter
  import mode_counter_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [2:0]       mode_data,
  input  logic [CNT_W-1:0] preset_in,
  input  logic             cnt_pulse,
  input  logic             cnt_up,
  input  logic             load_pulse,
  input  logic             clr_pulse,
  input  logic             clr_flags,
  input  logic             clr_err,
  input  logic             err_in,
  input  logic             idx_in,
  output logic [CNT_W-1:0] count_out,
  output logic [7:0]       flags_out,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             compare_n
);
  logic [2:0] mode_q;
  cmode_e     cmode;
  logic       accept, carry_ev, borrow_ev, cmp_ev;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 3'b000;
    else if (mode_wr) mode_q <= mode_data;
  end

  assign cmode = cmode_e'(mode_q[2:1]);

  mc_count_ctrl #(.WIDTH(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cnt_pulse  (cnt_pulse),
    .cnt_up     (cnt_up),
    .load_pulse (load_pulse),
    .clr_pulse  (clr_pulse),
    .mode_wr    (mode_wr),
    .mode       (cmode),
    .bcd        (mode_q[0]),
    .preset     (preset_in),
    .count_q    (count_out),
    .accept     (accept),
    .carry_ev   (carry_ev),
    .borrow_ev  (borrow_ev),
    .cmp_ev     (cmp_ev)
  );

  mc_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .cnt_up    (cnt_up),
    .carry_ev  (carry_ev),
    .borrow_ev (borrow_ev),
    .cmp_ev    (cmp_ev),
    .err_in    (err_in),
    .idx_in    (idx_in),
    .clr_flags (clr_flags),
    .clr_err   (clr_err),
    .flags     (flags_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_n   <= 1'b1;
      borrow_n  <= 1'b1;
      compare_n <= 1'b1;
    end else begin
      carry_n   <= ~carry_ev;
      borrow_n  <= ~borrow_ev;
      compare_n <= ~cmp_ev;
    end
  end

endmodule

// File: rtl/mode_counter_chk.sv
module mode_counter_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_pulse,
  input logic             cnt_up,
  input logic             load_pulse,
  input logic             clr_pulse,
  input logic             clr_flags,
  input logic             clr_err,
  input logic [CNT_W-1:0] preset_in,
  input logic [CNT_W-1:0] count_out,
  input logic [7:0]       flags_out,
  input logic             carry_n,
  input logic             borrow_n,
  input logic [2:0]       mode_q
);

  // R9
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(!carry_n && !borrow_n));

  // R5
  clamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2:1] == 2'b01 && cnt_pulse && cnt_up && count_out == preset_in
     && !clr_pulse && !load_pulse) |=> $stable(count_out));

  // R7
  wrapn_up_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2:1] == 2'b11 && cnt_pulse && cnt_up && count_out == preset_in
     && !clr_pulse && !load_pulse) |=> (count_out == '0 && !carry_n));

  // R10
  ct_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!carry_n && !$past(clr_flags) && !$past(rst)) |-> (flags_out[1] != $past(flags_out[1])));

  // R11
  sign_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!borrow_n && !$past(clr_flags) && !$past(rst)) |-> flags_out[3]);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flags_out[4]) && !$past(clr_err) && !$past(rst)) |-> flags_out[4]);

endmodule

bind mode_counter mode_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_pulse  (cnt_pulse),
  .cnt_up     (cnt_up),
  .load_pulse (load_pulse),
  .clr_pulse  (clr_pulse),
  .clr_flags  (clr_flags),
  .clr_err    (clr_err),
  .preset_in  (preset_in),
  .count_out  (count_out),
  .flags_out  (flags_out),
  .carry_n    (carry_n),
  .borrow_n   (borrow_n),
  .mode_q     (mode_q)
);

// File: tb/mode_counter_bench.sv
`timescale 1ns/1ps
module mode_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_data = 3'b000;
  logic [23:0] preset_in = '0;
  logic        cnt_pulse = 1'b0;
  logic        cnt_up = 1'b0;
  logic        load_pulse = 1'b0;
  logic        clr_pulse = 1'b0;
  logic        clr_flags = 1'b0;
  logic        clr_err = 1'b0;
  logic        err_in = 1'b0;
  logic        idx_in = 1'b0;
  logic [23:0] count_out;
  logic [7:0]  flags_out;
  logic        carry_n, borrow_n, compare_n;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mode_counter u_mode_counter (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_data(mode_data),
    .preset_in(preset_in), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
    .load_pulse(load_pulse), .clr_pulse(clr_pulse), .clr_flags(clr_flags),
    .clr_err(clr_err), .err_in(err_in), .idx_in(idx_in),
    .count_out(count_out), .flags_out(flags_out),
    .carry_n(carry_n), .borrow_n(borrow_n), .compare_n(compare_n)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [23:0] start;
    logic [23:0] pre;
    logic        up;
    logic [23:0] exp;
    logic        ecy;
    logic        ebw;
    logic        ecp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 24'hFFFFFF, 24'h000005, 1'b1, 24'h000000, 1'b0, 1'b1, 1'b1}, // R3
    '{3'b000, 24'h000000, 24'h000005, 1'b0, 24'hFFFFFF, 1'b1, 1'b0, 1'b1}, // R3
    '{3'b000, 24'h000123, 24'h000005, 1'b1, 24'h000124, 1'b1, 1'b1, 1'b1}, // R3
    '{3'b001, 24'h999999, 24'h000005, 1'b1, 24'h000000, 1'b0, 1'b1, 1'b1}, // R4
    '{3'b001, 24'h000000, 24'h000005, 1'b0, 24'h999999, 1'b1, 1'b0, 1'b1}, // R4
    '{3'b001, 24'h000199, 24'h000005, 1'b1, 24'h000200, 1'b1, 1'b1, 1'b1}, // R4
    '{3'b001, 24'h100000, 24'h000005, 1'b0, 24'h099999, 1'b1, 1'b1, 1'b1}, // R4
    '{3'b010, 24'h00000A, 24'h00000A, 1'b1, 24'h00000A, 1'b1, 1'b1, 1'b0}, // R5
    '{3'b010, 24'h000000, 24'h00000A, 1'b0, 24'h000000, 1'b1, 1'b1, 1'b1}, // R5
    '{3'b010, 24'h000009, 24'h00000A, 1'b1, 24'h00000A, 1'b1, 1'b1, 1'b0}, // R5 R8
    '{3'b110, 24'h00000A, 24'h00000A, 1'b1, 24'h000000, 1'b0, 1'b1, 1'b1}, // R7
    '{3'b110, 24'h000000, 24'h00000A, 1'b0, 24'h00000A, 1'b1, 1'b0, 1'b0}, // R7
    '{3'b110, 24'h000003, 24'h00000A, 1'b1, 24'h000004, 1'b1, 1'b1, 1'b1}, // R7
    '{3'b111, 24'h000099, 24'h000099, 1'b1, 24'h000000, 1'b0, 1'b1, 1'b1}, // R7 R4
    '{3'b100, 24'hFFFFFF, 24'h000005, 1'b1, 24'hFFFFFF, 1'b0, 1'b1, 1'b1}, // R6
    '{3'b100, 24'h000000, 24'h000005, 1'b0, 24'h000000, 1'b1, 1'b0, 1'b1}, // R6
    '{3'b000, 24'h000006, 24'h000005, 1'b0, 24'h000005, 1'b1, 1'b1, 1'b0}  // R8
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_wr = 1'b1; mode_data = m; step(); mode_wr = 1'b0;
  endtask

  task automatic load(input logic [23:0] v);
    preset_in = v; load_pulse = 1'b1; step(); load_pulse = 1'b0;
  endtask

  task automatic pulse(input logic up);
    cnt_pulse = 1'b1; cnt_up = up; step(); cnt_pulse = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk); step(); step();
    // R1 reset state
    chk("R1 count", count_out, 0);
    chk("R1 flags", flags_out, 0);
    chk("R1 pulses", {carry_n, borrow_n, compare_n}, 3'b111);
    rst = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      set_mode(VECS[i].mode);
      load(VECS[i].start);
      preset_in = VECS[i].pre;
      pulse(VECS[i].up);
      chk($sformatf("table[%0d] R3/R4/R5/R6/R7 count", i), count_out, VECS[i].exp);
      chk($sformatf("table[%0d] R8/R9 pulses", i), {carry_n, borrow_n, compare_n},
          {VECS[i].ecy, VECS[i].ebw, VECS[i].ecp});
    end

    // R6 one-shot stays halted, load resumes
    set_mode(3'b100); load(24'hFFFFFF); preset_in = 24'h000005;
    pulse(1'b1);
    pulse(1'b1);
    chk("R6 halted up", count_out, 24'hFFFFFF);
    chk("R6 no second carry", carry_n, 1'b1);
    pulse(1'b0);
    chk("R6 halted down", count_out, 24'hFFFFFF);
    load(24'h000010); pulse(1'b1);
    chk("R6 resumed after load", count_out, 24'h000011);

    // R5 reversal resumes
    set_mode(3'b010); load(24'h00000A);
    pulse(1'b1); pulse(1'b0);
    chk("R5 reverse", count_out, 24'h000009);

    // R9 pulse width one cycle
    set_mode(3'b000); load(24'hFFFFFF); preset_in = 24'h000005;
    pulse(1'b1);
    chk("R9 carry low", carry_n, 1'b0);
    step();
    chk("R9 carry released", carry_n, 1'b1);
    chk("R9 count kept", count_out, 24'h000000);

    // R2 BCD selection takes effect
    set_mode(3'b001); load(24'h000009); preset_in = 24'h000005;
    pulse(1'b1);
    chk("R2 bcd step", count_out, 24'h000010);

    // R10 R11 flag sequence
    set_mode(3'b000);
    clr_flags = 1'b1; step(); clr_flags = 1'b0;
    load(24'hFFFFFF); preset_in = 24'h000005;
    pulse(1'b1);
    chk("R10 R11 after carry", flags_out, 8'h22);
    pulse(1'b0);
    chk("R10 R11 after borrow", flags_out, 8'h0B);
    load(24'h000006); preset_in = 24'h000005;
    pulse(1'b0);
    chk("R10 after compare", flags_out, 8'h0F);
    clr_flags = 1'b1; step(); clr_flags = 1'b0;
    chk("R13 clr_flags", flags_out, 8'h00);

    // R12 sticky error
    err_in = 1'b1; step(); err_in = 1'b0;
    chk("R12 err set", flags_out, 8'h10);
    clr_flags = 1'b1; step(); clr_flags = 1'b0;
    chk("R12 err survives clr_flags", flags_out, 8'h10);
    clr_err = 1'b1; err_in = 1'b1; step(); clr_err = 1'b0; err_in = 1'b0;
    chk("R12 clear wins", flags_out, 8'h00);

    // R11 index
    idx_in = 1'b1; step();
    chk("R11 index", flags_out, 8'h40);
    idx_in = 1'b0; step();
    chk("R11 index low", flags_out, 8'h00);

    // R13 priority
    preset_in = 24'h000055;
    clr_pulse = 1'b1; load_pulse = 1'b1; cnt_pulse = 1'b1; cnt_up = 1'b1;
    step();
    clr_pulse = 1'b0;
    chk("R13 clear wins", count_out, 24'h000000);
    step();
    load_pulse = 1'b0; cnt_pulse = 1'b0;
    chk("R13 load over count", count_out, 24'h000055);

    summary();
  end
endmodule